// File: doc/BRIEF.md
# Boundary-scan test access controller

This block is a test access port for a small programmable device. It follows the state sequencing of IEEE 1149.1 and is clocked only by the test clock `tck_i`. A serial stream on `tdi_i`, steered by `tms_i`, loads a 4-bit instruction register. That instruction picks which data register sits between `tdi_i` and `tdo_o`: a 1-bit bypass register, a 32-bit identification register, or the boundary-scan register. The boundary-scan register is a chain of per-pin cells.

Each bidirectional pin cell has three scan stages and two update stages. The scan stages hold the pad input, the core output value and the core output enable. The update stages hold the driven output value and the driven output enable. A mode multiplexer in the cell chooses whether the core or the update stages drive the pad. Input-only pins get a cell with a single scan stage and no update stage.

There is no separate test reset pin. The power-on reset `rst_ni` places the controller in Test-Logic-Reset. `tdo_o` and `tdo_en_o` change on the falling edge of `tck_i`. The enable is asserted only while an instruction or data register is shifting.

Top module: `bscan_tap`

## Requirements
- R1: While `rst_ni` is low and after its release, the controller is in Test-Logic-Reset and `tdo_en_o` is 0. The active instruction is IDCODE, so the pads follow `core_out_i` and `core_oe_i`.
- R2: Five consecutive rising `tck_i` edges with `tms_i` high reach Test-Logic-Reset from any state. The edge that follows while in that state restores IDCODE as the active instruction.
- R3: The instruction register is 4 bits and is shifted LSB first. Capture-IR loads 4'b0001, so the low two bits are 01. Opcodes: EXTEST 4'h0, SAMPLE/PRELOAD 4'h1, IDCODE 4'h2, HIGHZ 4'h3, BYPASS 4'hF. Every other opcode acts as BYPASS.
- R4: Under IDCODE, Capture-DR loads the 32-bit `ID_VALUE` with bit 0 forced to 1. The register is shifted out LSB first.
- R5: Under BYPASS, and under any unassigned opcode, a single stage sits between `tdi_i` and `tdo_o`. Capture-DR loads it with 0.
- R6: Under HIGHZ, every bit of `pad_oe_o` is 0, and the 1-bit bypass stage is the data path.
- R7: The boundary-scan register has `NUM_IN + 3*NUM_IO` bits. Bit 0 is nearest `tdo_o`. For I/O pin k, bit 3k is the output enable, bit 3k+1 the output value and bit 3k+2 the pad input. Input-only pin j sits at bit `3*NUM_IO + j`. Under SAMPLE/PRELOAD, Capture-DR samples the live signals and Update-DR loads the update stages, while the pads keep following the core.
- R8: Under EXTEST, `pad_out_o` and `pad_oe_o` come from the update stages and ignore changes on the core inputs. Capture-DR still samples the live signals.
- R9: Input-only pin cells have a capture and shift stage only; they capture `in_pad_i`.
- R10: `tdo_en_o` is 1 exactly while the controller is in Shift-IR or Shift-DR. `tdo_o` and `tdo_en_o` update on the falling edge of `tck_i`, half a cycle after the state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| tms_i | input | 1 | Test mode select |
| tdi_i | input | 1 | Serial test data in |
| tdo_o | output | 1 | Serial test data out, falling-edge timed |
| tdo_en_o | output | 1 | Drive enable for tdo_o |
| io_pad_in_i | input | NUM_IO | Values seen at the bidirectional pads |
| in_pad_i | input | NUM_IN | Values at the input-only pads |
| core_out_i | input | NUM_IO | Output values from the core logic |
| core_oe_i | input | NUM_IO | Output enables from the core logic |
| pad_out_o | output | NUM_IO | Output value driven to the pads |
| pad_oe_o | output | NUM_IO | Output enable driven to the pads |

## Verification
The bench sets `ID_VALUE` with bit 0 clear. A register that does not force that bit would return the wrong identification word.

It preloads the update stages under SAMPLE/PRELOAD and then switches to EXTEST without shifting again. A design that loaded the update stages only under EXTEST, or that let the pads see the preload early, would drive the wrong pad values. While EXTEST is active the bench toggles the core inputs and checks that the pads hold.

The bench escapes from the middle of Shift-DR with five TMS-high edges. A controller that missed Test-Logic-Reset, or that did not restore IDCODE, would leave the pads under test control.

It also probes `tdo_en_o` just after the rising edge into Shift-DR. An enable timed on the wrong edge would show up there one half-cycle early.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  localparam int IR_W = 4;
  localparam int ID_W = 32;

  localparam logic [IR_W-1:0] OP_EXTEST = 4'h0;
  localparam logic [IR_W-1:0] OP_SAMPLE = 4'h1;
  localparam logic [IR_W-1:0] OP_IDCODE = 4'h2;
  localparam logic [IR_W-1:0] OP_HIGHZ  = 4'h3;
  localparam logic [IR_W-1:0] OP_BYPASS = 4'hF;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  typedef struct packed {
    logic tlr;
    logic capture_dr;
    logic shift_dr;
    logic update_dr;
    logic capture_ir;
    logic shift_ir;
    logic update_ir;
  } tap_ctl_t;

  typedef struct packed {
    logic extest;
    logic sample;
    logic idcode;
    logic highz;
    logic bypass;
  } ir_dec_t;

endpackage

// File: rtl/bscan_fsm.sv
module bscan_fsm
  import bscan_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o,
  output tap_ctl_t   ctl_o
);

  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_TLR:    state_d = tms_i ? ST_TLR    : ST_RTI;
      ST_RTI:    state_d = tms_i ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: state_d = tms_i ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms_i ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_d = tms_i ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_d = tms_i ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms_i ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms_i ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_d = tms_i ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: state_d = tms_i ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: state_d = tms_i ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_d = tms_i ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_d = tms_i ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms_i ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms_i ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_d = tms_i ? ST_SEL_DR : ST_RTI;
      default:   state_d = ST_TLR;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_TLR;
    else         state_q <= state_d;
  end

  assign state_o          = state_q;
  assign ctl_o.tlr        = (state_q == ST_TLR);
  assign ctl_o.capture_dr = (state_q == ST_CAP_DR);
  assign ctl_o.shift_dr   = (state_q == ST_SH_DR);
  assign ctl_o.update_dr  = (state_q == ST_UPD_DR);
  assign ctl_o.capture_ir = (state_q == ST_CAP_IR);
  assign ctl_o.shift_ir   = (state_q == ST_SH_IR);
  assign ctl_o.update_ir  = (state_q == ST_UPD_IR);

  // R2
  tlr_hold_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q == ST_TLR && tms_i) |=> (state_q == ST_TLR));

  // R2
  sel_ir_escape_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q == ST_SEL_IR && tms_i) |=> (state_q == ST_TLR));

endmodule

// File: rtl/bscan_ir.sv
module bscan_ir
  import bscan_pkg::*;
(
  input  logic    tck_i,
  input  logic    rst_ni,
  input  logic    tdi_i,
  input  logic    tlr_i,
  input  logic    capture_i,
  input  logic    shift_i,
  input  logic    update_i,
  output logic    tdo_o,
  output ir_dec_t dec_o
);

  logic [IR_W-1:0] ir_sr_q, ir_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)        ir_sr_q <= IR_CAPTURE;
    else if (capture_i) ir_sr_q <= IR_CAPTURE;
    else if (shift_i)   ir_sr_q <= {tdi_i, ir_sr_q[IR_W-1:1]};
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)       ir_q <= OP_IDCODE;
    else if (tlr_i)    ir_q <= OP_IDCODE;
    else if (update_i) ir_q <= ir_sr_q;
  end

  always_comb begin
    dec_o = '0;
    unique case (ir_q)
      OP_EXTEST: dec_o.extest = 1'b1;
      OP_SAMPLE: dec_o.sample = 1'b1;
      OP_IDCODE: dec_o.idcode = 1'b1;
      OP_HIGHZ:  dec_o.highz  = 1'b1;
      default:   dec_o.bypass = 1'b1;
    endcase
  end

  assign tdo_o = ir_sr_q[0];

  // R3
  ir_capture_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    capture_i |=> (ir_sr_q[1:0] == 2'b01));

  // R1
  ir_reset_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tlr_i |=> (ir_q == OP_IDCODE));

  // R3
  ir_onehot_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $countones(dec_o) == 1);

endmodule

// File: rtl/bscan_io_cell.sv
module bscan_io_cell (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic scan_i,
  input  logic capture_i,
  input  logic shift_i,
  input  logic update_i,
  input  logic extest_i,
  input  logic highz_i,
  input  logic pad_in_i,
  input  logic core_out_i,
  input  logic core_oe_i,
  output logic scan_o,
  output logic pad_out_o,
  output logic pad_oe_o
);

  logic cap_in_q, cap_out_q, cap_oe_q;
  logic upd_out_q, upd_oe_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_in_q  <= 1'b0;
      cap_out_q <= 1'b0;
      cap_oe_q  <= 1'b0;
    end else if (capture_i) begin
      cap_in_q  <= pad_in_i;
      cap_out_q <= core_out_i;
      cap_oe_q  <= core_oe_i;
    end else if (shift_i) begin
      cap_in_q  <= scan_i;
      cap_out_q <= cap_in_q;
      cap_oe_q  <= cap_out_q;
    end
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_out_q <= 1'b0;
      upd_oe_q  <= 1'b0;
    end else if (update_i) begin
      upd_out_q <= cap_out_q;
      upd_oe_q  <= cap_oe_q;
    end
  end

  assign scan_o    = cap_oe_q;
  assign pad_out_o = extest_i ? upd_out_q : core_out_i;
  assign pad_oe_o  = highz_i ? 1'b0 : (extest_i ? upd_oe_q : core_oe_i);

  // R7
  upd_load_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    update_i |=> (upd_out_q == $past(cap_out_q) && upd_oe_q == $past(cap_oe_q)));

  // R8
  upd_hold_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !update_i |=> $stable(upd_out_q) && $stable(upd_oe_q));

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain #(
  parameter int NUM_IO = 4,
  parameter int NUM_IN = 2
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              tdi_i,
  input  logic              capture_i,
  input  logic              shift_i,
  input  logic              update_i,
  input  logic              extest_i,
  input  logic              highz_i,
  input  logic [NUM_IO-1:0] io_pad_in_i,
  input  logic [NUM_IN-1:0] in_pad_i,
  input  logic [NUM_IO-1:0] core_out_i,
  input  logic [NUM_IO-1:0] core_oe_i,
  output logic              tdo_o,
  output logic [NUM_IO-1:0] pad_out_o,
  output logic [NUM_IO-1:0] pad_oe_o
);

  localparam int BSR_LEN = NUM_IN + 3 * NUM_IO;
  localparam int IN_BASE = 3 * NUM_IO;

  logic [BSR_LEN:0] link;
  assign link[BSR_LEN] = tdi_i;
  assign tdo_o         = link[0];

  for (genvar k = 0; k < NUM_IO; k++) begin : g_io
    bscan_io_cell i_cell (
      .tck_i      (tck_i),
      .rst_ni     (rst_ni),
      .scan_i     (link[3*k+3]),
      .capture_i  (capture_i),
      .shift_i    (shift_i),
      .update_i   (update_i),
      .extest_i   (extest_i),
      .highz_i    (highz_i),
      .pad_in_i   (io_pad_in_i[k]),
      .core_out_i (core_out_i[k]),
      .core_oe_i  (core_oe_i[k]),
      .scan_o     (link[3*k]),
      .pad_out_o  (pad_out_o[k]),
      .pad_oe_o   (pad_oe_o[k])
    );
    // interior stages of the cell are not exposed on the link
    assign link[3*k+1] = 1'b0;
    assign link[3*k+2] = 1'b0;
  end

  for (genvar j = 0; j < NUM_IN; j++) begin : g_in
    localparam int POS = IN_BASE + j;
    logic cap_q;
    always_ff @(posedge tck_i or negedge rst_ni) begin
      if (!rst_ni)        cap_q <= 1'b0;
      else if (capture_i) cap_q <= in_pad_i[j];
      else if (shift_i)   cap_q <= link[POS+1];
    end
    assign link[POS] = cap_q;

    // R9
    in_cap_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
      capture_i |=> (cap_q == $past(in_pad_i[j])));
  end

endmodule

// File: rtl/bscan_tap.sv
module bscan_tap
  import bscan_pkg::*;
#(
  parameter int          NUM_IO   = 4,
  parameter int          NUM_IN   = 2,
  parameter logic [31:0] ID_VALUE = 32'h1504_A03F
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              tms_i,
  input  logic              tdi_i,
  output logic              tdo_o,
  output logic              tdo_en_o,
  input  logic [NUM_IO-1:0] io_pad_in_i,
  input  logic [NUM_IN-1:0] in_pad_i,
  input  logic [NUM_IO-1:0] core_out_i,
  input  logic [NUM_IO-1:0] core_oe_i,
  output logic [NUM_IO-1:0] pad_out_o,
  output logic [NUM_IO-1:0] pad_oe_o
);

  tap_state_e state;
  tap_ctl_t   ctl;
  ir_dec_t    dec;
  logic       ir_tdo, chain_tdo, bsr_sel, byp_sel;
  logic       byp_q, dr_tdo, tdo_d, tdo_q, tdo_en_q;
  logic [ID_W-1:0] id_sr_q;

  bscan_fsm i_fsm (
    .tck_i   (tck_i),
    .rst_ni  (rst_ni),
    .tms_i   (tms_i),
    .state_o (state),
    .ctl_o   (ctl)
  );

  bscan_ir i_ir (
    .tck_i     (tck_i),
    .rst_ni    (rst_ni),
    .tdi_i     (tdi_i),
    .tlr_i     (ctl.tlr),
    .capture_i (ctl.capture_ir),
    .shift_i   (ctl.shift_ir),
    .update_i  (ctl.update_ir),
    .tdo_o     (ir_tdo),
    .dec_o     (dec)
  );

  assign bsr_sel = dec.extest | dec.sample;
  assign byp_sel = dec.bypass | dec.highz;

  bscan_chain #(
    .NUM_IO (NUM_IO),
    .NUM_IN (NUM_IN)
  ) i_chain (
    .tck_i       (tck_i),
    .rst_ni      (rst_ni),
    .tdi_i       (tdi_i),
    .capture_i   (ctl.capture_dr & bsr_sel),
    .shift_i     (ctl.shift_dr & bsr_sel),
    .update_i    (ctl.update_dr & bsr_sel),
    .extest_i    (dec.extest),
    .highz_i     (dec.highz),
    .io_pad_in_i (io_pad_in_i),
    .in_pad_i    (in_pad_i),
    .core_out_i  (core_out_i),
    .core_oe_i   (core_oe_i),
    .tdo_o       (chain_tdo),
    .pad_out_o   (pad_out_o),
    .pad_oe_o    (pad_oe_o)
  );

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                          byp_q <= 1'b0;
    else if (ctl.capture_dr && byp_sel)   byp_q <= 1'b0;
    else if (ctl.shift_dr && byp_sel)     byp_q <= tdi_i;
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                            id_sr_q <= '0;
    else if (ctl.capture_dr && dec.idcode)  id_sr_q <= {ID_VALUE[ID_W-1:1], 1'b1};
    else if (ctl.shift_dr && dec.idcode)    id_sr_q <= {tdi_i, id_sr_q[ID_W-1:1]};
  end

  always_comb begin
    if (dec.idcode)   dr_tdo = id_sr_q[0];
    else if (bsr_sel) dr_tdo = chain_tdo;
    else if (byp_sel) dr_tdo = byp_q;
    else              dr_tdo = 1'b0;
  end

  assign tdo_d = ctl.shift_ir ? ir_tdo : dr_tdo;

  // output side is retimed to the falling test-clock edge
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_q    <= 1'b0;
      tdo_en_q <= 1'b0;
    end else begin
      tdo_q    <= tdo_d;
      tdo_en_q <= ctl.shift_ir | ctl.shift_dr;
    end
  end

  assign tdo_o    = tdo_q;
  assign tdo_en_o = tdo_en_q;

  // R10
  tdo_en_state_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_en_o == (state == ST_SH_IR || state == ST_SH_DR));

  // R6
  highz_oe_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    dec.highz |-> (pad_oe_o == '0));

  // R4
  id_lsb_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (ctl.capture_dr && dec.idcode) |=> id_sr_q[0]);

  // R5
  byp_capture_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (ctl.capture_dr && byp_sel) |=> !byp_q);

  // R7
  sample_follow_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    dec.sample |-> (pad_out_o == core_out_i && pad_oe_o == core_oe_i));

endmodule

// File: tb/test_bscan_tap.sv
module test_bscan_tap;

  localparam int NIO = 4;
  localparam int NIN = 2;
  localparam int BL  = NIN + 3 * NIO;
  localparam logic [31:0] ID  = 32'h1234_5678;
  localparam logic [31:0] IDX = 32'h1234_5679;

  logic tck = 1'b0, rst_ni = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdo_en;
  logic [NIO-1:0] io_in = '0, core_out = '0, core_oe = '0, pad_out, pad_oe;
  logic [NIN-1:0] in_pad = '0;

  int checks = 0, fails = 0;
  logic done = 1'b0;
  logic last_en;

  always #4 tck = ~tck;

  bscan_tap #(.NUM_IO(NIO), .NUM_IN(NIN), .ID_VALUE(ID)) i_bscan_tap (
    .tck_i(tck), .rst_ni(rst_ni), .tms_i(tms), .tdi_i(tdi),
    .tdo_o(tdo), .tdo_en_o(tdo_en),
    .io_pad_in_i(io_in), .in_pad_i(in_pad),
    .core_out_i(core_out), .core_oe_i(core_oe),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic t_ms, input logic t_di, output logic t_do);
    @(negedge tck);
    #1;
    t_do    = tdo;
    last_en = tdo_en;
    tms     = t_ms;
    tdi     = t_di;
  endtask

  task automatic idle();
    logic d;
    step(1'b0, 1'b0, d);
  endtask

  task automatic scan_ir(input logic [3:0] op, output logic [3:0] cap);
    logic d;
    step(1'b1, 1'b0, d);
    step(1'b1, 1'b0, d);
    step(1'b0, 1'b0, d);
    step(1'b0, 1'b0, d);
    for (int i = 0; i < 4; i++) begin
      step(i == 3, op[i], d);
      cap[i] = d;
    end
    step(1'b1, 1'b0, d);
    step(1'b0, 1'b0, d);
    idle();
  endtask

  task automatic scan_dr(input int len, input logic [63:0] din, output logic [63:0] dout);
    logic d;
    dout = '0;
    step(1'b1, 1'b0, d);
    step(1'b0, 1'b0, d);
    step(1'b0, 1'b0, d);
    for (int i = 0; i < len; i++) begin
      step(i == len - 1, din[i], d);
      dout[i] = d;
    end
    step(1'b1, 1'b0, d);
    step(1'b0, 1'b0, d);
    idle();
  endtask

  function automatic logic [63:0] live_vec();
    logic [63:0] v = '0;
    for (int k = 0; k < NIO; k++) begin
      v[3*k]   = core_oe[k];
      v[3*k+1] = core_out[k];
      v[3*k+2] = io_in[k];
    end
    for (int j = 0; j < NIN; j++) v[3*NIO+j] = in_pad[j];
    return v;
  endfunction

  function automatic logic [NIO-1:0] upd_out(input logic [63:0] v);
    logic [NIO-1:0] r;
    for (int k = 0; k < NIO; k++) r[k] = v[3*k+1];
    return r;
  endfunction

  function automatic logic [NIO-1:0] upd_oe(input logic [63:0] v);
    logic [NIO-1:0] r;
    for (int k = 0; k < NIO; k++) r[k] = v[3*k];
    return r;
  endfunction

  task automatic t_reset();
    logic [63:0] o;
    core_out = 4'b1010;
    core_oe  = 4'b0110;
    #1;
    chk("R1 tdo_en in reset", 64'(tdo_en), 64'd0);
    rst_ni = 1'b1;
    idle();
    idle();
    chk("R1 tdo_en after reset", 64'(tdo_en), 64'd0);
    chk("R1 pad_out follows core", 64'(pad_out), 64'(core_out));
    chk("R1 pad_oe follows core", 64'(pad_oe), 64'(core_oe));
    scan_dr(32, 64'hFFFF_FFFF, o);
    chk("R4 idcode after reset", o[31:0], 64'(IDX));
  endtask

  task automatic t_ir_capture();
    logic [3:0] c;
    scan_ir(4'hF, c);
    chk("R3 ir capture pattern", 64'(c), 64'd1);
  endtask

  task automatic t_bypass(input logic [3:0] op, input string tag);
    logic [3:0] c;
    logic [63:0] o;
    logic [63:0] b = 64'hB5;
    scan_ir(op, c);
    scan_dr(8, b, o);
    chk(tag, o[7:0], {b[6:0], 1'b0});
  endtask

  task automatic t_sample(output logic [63:0] pre);
    logic [3:0] c;
    logic [63:0] o, exp;
    io_in = 4'b1100; in_pad = 2'b01; core_out = 4'b0101; core_oe = 4'b1011;
    pre = 64'h2A5B & ((64'd1 << BL) - 1);
    scan_ir(4'h1, c);
    exp = live_vec();
    scan_dr(BL, pre, o);
    chk("R7 sample capture order", o & ((64'd1 << BL) - 1), exp);
    chk("R9 input-only capture", 64'(o[BL-1 -: NIN]), 64'(in_pad));
    chk("R7 pads follow core in sample", 64'({pad_out, pad_oe}), 64'({core_out, core_oe}));
  endtask

  task automatic t_extest(input logic [63:0] pre);
    logic [3:0] c;
    logic [63:0] o, exp, q;
    scan_ir(4'h0, c);
    chk("R8 pad_out from preload", 64'(pad_out), 64'(upd_out(pre)));
    chk("R8 pad_oe from preload", 64'(pad_oe), 64'(upd_oe(pre)));
    core_out = ~core_out; core_oe = ~core_oe; io_in = 4'b0011; in_pad = 2'b10;
    idle();
    chk("R8 pads ignore core", 64'({pad_out, pad_oe}), 64'({upd_out(pre), upd_oe(pre)}));
    q = 64'h1C3A & ((64'd1 << BL) - 1);
    exp = live_vec();
    scan_dr(BL, q, o);
    chk("R8 extest capture live", o & ((64'd1 << BL) - 1), exp);
    chk("R8 pads from new update", 64'({pad_out, pad_oe}), 64'({upd_out(q), upd_oe(q)}));
  endtask

  task automatic t_highz();
    logic [3:0] c;
    logic [63:0] o;
    core_oe = 4'hF; core_out = 4'b0110;
    scan_ir(4'h3, c);
    chk("R6 highz oe off", 64'(pad_oe), 64'd0);
    chk("R6 highz out from core", 64'(pad_out), 64'(core_out));
    scan_dr(6, 64'h2D, o);
    chk("R6 highz bypass path", o[5:0], 64'({6'h2D, 1'b0} & 7'h3F));
  endtask

  task automatic t_tdo_timing();
    logic d;
    step(1'b1, 1'b0, d);
    step(1'b0, 1'b0, d);
    step(1'b0, 1'b0, d);
    chk("R10 en off in capture", 64'(last_en), 64'd0);
    @(posedge tck); #1;
    chk("R10 en waits for falling edge", 64'(tdo_en), 64'd0);
    @(negedge tck); #1;
    chk("R10 en on in shift", 64'(tdo_en), 64'd1);
    step(1'b1, 1'b0, d);
    step(1'b1, 1'b0, d);
    chk("R10 en off in exit", 64'(last_en), 64'd0);
    step(1'b0, 1'b0, d);
    idle();
  endtask

  task automatic t_tms_reset();
    logic [3:0] c;
    logic [63:0] o;
    logic d;
    core_oe = 4'b0101; core_out = 4'b0011;
    scan_ir(4'h0, c);
    step(1'b1, 1'b0, d);
    step(1'b0, 1'b0, d);
    step(1'b0, 1'b0, d);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, d);
    step(1'b0, 1'b0, d);
    idle();
    chk("R2 pads back to core", 64'({pad_out, pad_oe}), 64'({core_out, core_oe}));
    scan_dr(32, 64'h0, o);
    chk("R2 idcode restored", o[31:0], 64'(IDX));
  endtask

  initial begin
    logic [63:0] pre;
    t_reset();
    t_ir_capture();
    t_bypass(4'hF, "R5 bypass one stage");
    t_bypass(4'h9, "R5 unassigned opcode bypass");
    t_sample(pre);
    t_extest(pre);
    t_highz();
    t_tdo_timing();
    t_tms_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge tck);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule